// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block generates the internal reset for a USB-to-serial bridge and drives a reset output pin that other devices on the board can share. It leaves reset only when three conditions hold at once: the supply is good, the reference oscillator runs, and the active-low external reset pin is high. Once all three hold, it waits a fixed number of clock cycles before it lets go.

While in reset the output pin is pulled low. After release the pin is no longer driven, and an external pull-up or the pad's weak-high state sets its level. The pin is modelled as an output-enable plus a data bit that is always 0. A low level on the external reset pin puts the block back into reset at once, without waiting for a clock edge. The supply-good and oscillator-running levels arrive as digital signals synchronous to `clk_i`. The external pin passes through a synchronizer before it can release reset.

Top module: `por_seq`

## Requirements
- R1: While the block is in reset, `rst_o` is 1, `rst_pin_oe_o` is 1 and `rst_pin_o` is 0. `rst_pin_o` is 0 at all times.
- R2: `rst_o` stays 1 whenever `supply_ok_i` or `osc_ok_i` is low, or `rst_ni` is low, for any length of time.
- R3: With the supply and oscillator already good, `rst_o` falls on the rising edge of `clk_i` that comes HOLD_CYCLES+2 edges after `rst_ni` rises (two edges of synchronizer, then HOLD_CYCLES edges of hold-off).
- R4: `rst_pin_oe_o` falls to 0 on the same clock edge on which `rst_o` falls, and it stays 0 for as long as `rst_o` is 0.
- R5: A falling `rst_ni` sets `rst_o` and `rst_pin_oe_o` to 1 at once, before the next clock edge.
- R6: If a qualifier drops during the hold-off, the count restarts. Release then comes on the HOLD_CYCLES-th rising edge at which all qualifiers are sampled high, counted from the edge on which they are high again.
- R7: After release, a low `supply_ok_i` or `osc_ok_i` sampled on a rising edge sets `rst_o` and `rst_pin_oe_o` to 1 on that same edge.
- R8: `rst_ni` passes through a synchronizer of SYNC_STAGES (default 2) flops before it counts as a qualifier. Its rising edge cannot start the hold-off earlier than this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | External reset pin, active low, asynchronous assertion |
| supply_ok_i | input | 1 | Supply above threshold, synchronous to clk_i |
| osc_ok_i | input | 1 | Oscillator running, synchronous to clk_i |
| rst_o | output | 1 | Internal reset, active high |
| rst_pin_oe_o | output | 1 | Reset pin output enable, 1 while in reset |
| rst_pin_o | output | 1 | Reset pin data, always 0 |

## Verification
The bench counts the exact number of edges from the rise of the external pin to the release. A missing or extra synchronizer stage, or an off-by-one in the hold-off compare, shifts this count by one. It drops the supply in the middle of a hold-off and checks for a full-length count after recovery; a counter that holds its value instead of clearing would release early. It pulls the external pin low halfway through a clock period and checks the outputs before the next edge, which finds a reset that asserts only synchronously. A random phase toggles all three qualifiers and compares every cycle against a bench model, which finds an output enable that does not follow the internal reset.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned DEF_HOLD_CYCLES = 30000;  // 5 ms at 6 MHz
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic supply;
    logic osc;
    logic ext;
  } qual_t;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  // clears at once on rst_ni low, fills with ones after release
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else if (i == 0) q[i] <= 1'b1;
      else q[i] <= q[i-1];
    end
  end

  assign sync_o = q[STAGES-1];

  assert_sync_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(q[0]));
endmodule

// File: rtl/por_qual.sv
module por_qual
  import por_pkg::*;
(
  input  qual_t q_i,
  output logic  all_ok_o
);
  assign all_ok_o = &q_i;
endmodule

// File: rtl/por_holdoff.sv
module por_holdoff #(
  parameter int unsigned HOLD_CYCLES = 30000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic all_ok_i,
  output logic in_reset_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          in_reset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      in_reset_q <= 1'b1;
    end else if (!all_ok_i) begin
      cnt_q      <= '0;
      in_reset_q <= 1'b1;
    end else if (in_reset_q) begin
      if (cnt_q == LAST) in_reset_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign in_reset_o = in_reset_q;

  initial assert (HOLD_CYCLES >= 2);

  assert_drop_resets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_ok_i |=> in_reset_q);
  assert_drop_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_ok_i |=> cnt_q == '0);
  assert_release_needs_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_reset_q) |-> $past(all_ok_i));
  assert_no_early_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_reset_q && cnt_q != LAST) |=> in_reset_q);
endmodule

// File: rtl/por_seq.sv
module por_seq
  import por_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = DEF_HOLD_CYCLES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic osc_ok_i,
  output logic rst_o,
  output logic rst_pin_oe_o,
  output logic rst_pin_o
);
  logic  ext_ok;
  logic  all_ok;
  logic  in_reset;
  qual_t qual;

  por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_o(ext_ok)
  );

  assign qual = '{supply: supply_ok_i, osc: osc_ok_i, ext: ext_ok};

  por_qual u_qual (
    .q_i     (qual),
    .all_ok_o(all_ok)
  );

  por_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .all_ok_i  (all_ok),
    .in_reset_o(in_reset)
  );

  // open-drain style pin: pull low in reset, float otherwise
  assign rst_o        = in_reset;
  assign rst_pin_oe_o = in_reset;
  assign rst_pin_o    = 1'b0;

  assert_pin_low_in_reset_R5: assert property (@(posedge clk_i)
    !rst_ni |-> (rst_o && rst_pin_oe_o));
endmodule

// File: tb/sim_por_seq.sv
module sim_por_seq;
  localparam int unsigned HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic supply = 1'b0;
  logic osc = 1'b0;
  logic rst_int, pin_oe, pin_d;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  por_seq #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .supply_ok_i (supply),
    .osc_ok_i    (osc),
    .rst_o       (rst_int),
    .rst_pin_oe_o(pin_oe),
    .rst_pin_o   (pin_d)
  );

  always #10 clk = ~clk;

  // reference model: sync depth and run of qualifying edges
  int m_sync = 0;
  int m_run = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0;
      m_run  = 0;
    end else begin
      if (m_sync >= 2 && supply && osc) m_run = (m_run < HOLD) ? m_run + 1 : m_run;
      else m_run = 0;
      m_sync = (m_sync < 2) ? m_sync + 1 : 2;
    end
  end

  function automatic logic exp_rst();
    return (!rst_n) || (m_run < HOLD);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // edges from now until rst_int falls, sampled 5 ns after each edge
  task automatic count_to_release(output int n);
    n = 0;
    do begin
      @(posedge clk); #5; n++;
    end while (rst_int && n < 10 * HOLD);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    #1 rst_n = 1'b0;
    #1;
    // R1 reset state
    chk("R1 rst_o", rst_int, 1'b1);
    chk("R1 oe", pin_oe, 1'b1);
    chk("R1 data", pin_d, 1'b0);

    // R2: pin released, supply missing for a long time
    @(negedge clk); rst_n = 1'b1; osc = 1'b1;
    repeat (3 * HOLD) @(posedge clk);
    #5 chk("R2 no supply", rst_int, 1'b1);

    // R3/R8: exact latency from pin rise
    @(negedge clk); rst_n = 1'b0; supply = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    count_to_release(n);
    chk_int("R3 R8 release edges", n, HOLD + 2);
    chk("R4 oe released", pin_oe, 1'b0);
    chk("R1 data", pin_d, 1'b0);
    @(posedge clk); #5 chk("R4 oe stays low", pin_oe, 1'b0);

    // R7: oscillator drop after release
    @(negedge clk); osc = 1'b0;
    @(posedge clk); #5;
    chk("R7 rst_o", rst_int, 1'b1);
    chk("R7 oe", pin_oe, 1'b1);
    @(negedge clk); osc = 1'b1;
    count_to_release(n);
    chk_int("R6 R7 recount", n, HOLD);

    // R6: supply drop mid hold-off restarts count
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2 + HOLD / 2) @(posedge clk);
    @(negedge clk); supply = 1'b0;
    @(posedge clk); #5 chk("R2 R6 in reset", rst_int, 1'b1);
    @(negedge clk); supply = 1'b1;
    count_to_release(n);
    chk_int("R6 full recount", n, HOLD);

    // R5: asynchronous assertion mid-period
    @(posedge clk); #3 rst_n = 1'b0;
    #1;
    chk("R5 rst_o async", rst_int, 1'b1);
    chk("R5 oe async", pin_oe, 1'b1);
    chk("R1 data", pin_d, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // random phase against model
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk); #5;
      chk("R1 R2 model rst_o", rst_int, exp_rst());
      chk("R4 model oe", pin_oe, exp_rst());
      chk("R1 model data", pin_d, 1'b0);
      #5;
      if (!rst_n) rst_n = ($urandom_range(3) == 0);
      else rst_n = ($urandom_range(299) != 0);
      if (!supply) supply = ($urandom_range(3) == 0);
      else supply = ($urandom_range(199) != 0);
      if (!osc) osc = ($urandom_range(3) == 0);
      else osc = ($urandom_range(199) != 0);
    end
    finish_run();
  end
endmodule